// File: doc/BRIEF.md
# Multidrop 9-bit Receive Address Filter

This block sits after the receive deserializer of a UART that runs in 9-bit multidrop mode. Each received character has eight data bits and a ninth flag that marks it as an address (1) or as data (0). In 9-bit mode, that ninth bit takes the place of parity. For each character the block decides whether to pass it on to the receive buffer or to discard it. The result is a registered, one-cycle accept or drop pulse. An accepted character is presented on the output together with its flag.

The decision rests on a receive-gate flag. While the gate is closed (1), data characters are thrown away. While it is open (0), they pass. The host can write the gate at any time. When auto-addressing is on, the hardware opens the gate itself for an address character that hits the node. A hit is either the programmed node address or the broadcast address, both compared only on the bits where the mask is 1. The broadcast address is the node address ORed with the mask, which means all mask bits must be 1. An address character that misses closes the gate and is dropped. With 9-bit mode off, every character passes and the gate is left alone.

Top module: `mdrop_addr_filter`

## Requirements
- R1: In the cycle after synchronous reset, gate_active is 1 and out_accept and out_drop are 0.
- R2: With cfg_nine_bit_en at 0, every valid character is accepted one cycle later, whatever its flag, cfg_auto_addr or the gate. gate_active is unchanged by the character.
- R3: With cfg_nine_bit_en at 1 and gate_active at 1, a character with rx_addr_flag at 0 gives an out_drop pulse one cycle later and no accept.
- R4: With cfg_nine_bit_en at 1 and gate_active at 0, a character with rx_addr_flag at 0 is accepted one cycle later.
- R5: A cycle with host_gate_wr at 1 loads host_gate_val into gate_active at the next edge. This takes priority over any gate change caused by a character in the same cycle.
- R6: With cfg_nine_bit_en at 1 and cfg_auto_addr at 0, a character with rx_addr_flag at 1 is always accepted and leaves gate_active unchanged.
- R7: With cfg_nine_bit_en and cfg_auto_addr at 1, an address character that equals cfg_node_addr on every bit where cfg_node_mask is 1 is accepted, and gate_active becomes 0.
- R8: With cfg_nine_bit_en and cfg_auto_addr at 1, an address character with 1 on every bit where cfg_node_mask is 1 (the broadcast address) is accepted, and gate_active becomes 0.
- R9: With cfg_nine_bit_en and cfg_auto_addr at 1, an address character that hits neither address is dropped, and gate_active becomes 1.
- R10: Each valid character yields exactly one of out_accept or out_drop, one cycle later. Neither pulses in any other cycle.
- R11: During an out_accept pulse, out_data and out_addr_flag hold the accepted character's data and flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_nine_bit_en | input | 1 | 1 selects 9-bit multidrop mode |
| cfg_auto_addr | input | 1 | 1 lets hardware open or close the gate on address characters |
| cfg_node_addr | input | DATA_W | Node address |
| cfg_node_mask | input | DATA_W | Mask; 1 marks a compared bit |
| host_gate_wr | input | 1 | Host write strobe for the gate flag |
| host_gate_val | input | 1 | Value written to the gate flag |
| rx_valid | input | 1 | A received character is present this cycle |
| rx_data | input | DATA_W | Received data bits |
| rx_addr_flag | input | 1 | Ninth bit: 1 address, 0 data |
| out_accept | output | 1 | Pulse: character passed to receive buffer |
| out_drop | output | 1 | Pulse: character discarded |
| out_data | output | DATA_W | Data of the last accepted character |
| out_addr_flag | output | 1 | Flag of the last accepted character |
| gate_active | output | 1 | Current gate flag; 1 drops data characters |

## Verification
The bench checks several cases:
- **Node and broadcast hits under a partial mask.** A design that compares masked-off bits, or that builds the broadcast without the mask, would drop valid addresses.
- **A miss followed by data.** This exposes a gate that fails to close again.
- **A host write in the same cycle as a missing address character.** A design with the wrong priority leaves the gate closed.
- **Address characters with auto-addressing off, and any character with 9-bit mode off.** A design that applies the gate or the matcher outside its mode would drop these characters or move the flag.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;

  typedef enum logic [1:0] {
    VERDICT_NONE   = 2'd0,
    VERDICT_ACCEPT = 2'd1,
    VERDICT_DROP   = 2'd2
  } verdict_e;

endpackage

// File: rtl/mdrop_addr_match.sv
module mdrop_addr_match #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] char_bits,
  input  logic [DATA_W-1:0] node_addr,
  input  logic [DATA_W-1:0] node_mask,
  output logic              any_hit
);

  logic [DATA_W-1:0] node_ok;
  logic [DATA_W-1:0] bcast_ok;

  // Per bit: a masked-off bit always agrees; a compared bit must equal
  // the node address (unicast) or be 1 (broadcast = addr | mask).
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign node_ok[b]  = ~node_mask[b] | ~(char_bits[b] ^ node_addr[b]);
    assign bcast_ok[b] = ~node_mask[b] | char_bits[b];
  end

  assign any_hit = (&node_ok) | (&bcast_ok);

endmodule

// File: rtl/mdrop_gate_ctrl.sv
module mdrop_gate_ctrl
  import mdrop_pkg::*;
#(
  parameter bit GATE_RST = 1'b1
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     nine_bit_en,
  input  logic     auto_addr,
  input  logic     char_valid,
  input  logic     char_is_addr,
  input  logic     any_hit,
  input  logic     host_wr,
  input  logic     host_val,
  output logic     gate_q,
  output verdict_e verdict
);

  logic gate_d;

  always_comb begin
    verdict = VERDICT_NONE;
    gate_d  = gate_q;
    if (char_valid) begin
      if (!nine_bit_en) begin
        verdict = VERDICT_ACCEPT;
      end else if (char_is_addr) begin
        if (auto_addr) begin
          if (any_hit) begin
            verdict = VERDICT_ACCEPT;
            gate_d  = 1'b0;
          end else begin
            verdict = VERDICT_DROP;
            gate_d  = 1'b1;
          end
        end else begin
          verdict = VERDICT_ACCEPT;
        end
      end else begin
        verdict = gate_q ? VERDICT_DROP : VERDICT_ACCEPT;
      end
    end
    // host write wins over any character-driven update
    if (host_wr) begin
      gate_d = host_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= GATE_RST;
    end else begin
      gate_q <= gate_d;
    end
  end

endmodule

// File: rtl/mdrop_addr_filter.sv
module mdrop_addr_filter
  import mdrop_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter bit GATE_RST = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_nine_bit_en,
  input  logic              cfg_auto_addr,
  input  logic [DATA_W-1:0] cfg_node_addr,
  input  logic [DATA_W-1:0] cfg_node_mask,
  input  logic              host_gate_wr,
  input  logic              host_gate_val,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_addr_flag,
  output logic              out_accept,
  output logic              out_drop,
  output logic [DATA_W-1:0] out_data,
  output logic              out_addr_flag,
  output logic              gate_active
);

  logic     hit;
  verdict_e verdict;

  mdrop_addr_match #(
    .DATA_W(DATA_W)
  ) u_match (
    .char_bits(rx_data),
    .node_addr(cfg_node_addr),
    .node_mask(cfg_node_mask),
    .any_hit  (hit)
  );

  mdrop_gate_ctrl #(
    .GATE_RST(GATE_RST)
  ) u_gate (
    .clk         (clk),
    .rst         (rst),
    .nine_bit_en (cfg_nine_bit_en),
    .auto_addr   (cfg_auto_addr),
    .char_valid  (rx_valid),
    .char_is_addr(rx_addr_flag),
    .any_hit     (hit),
    .host_wr     (host_gate_wr),
    .host_val    (host_gate_val),
    .gate_q      (gate_active),
    .verdict     (verdict)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_accept    <= 1'b0;
      out_drop      <= 1'b0;
      out_data      <= '0;
      out_addr_flag <= 1'b0;
    end else begin
      out_accept <= (verdict == VERDICT_ACCEPT);
      out_drop   <= (verdict == VERDICT_DROP);
      if (verdict == VERDICT_ACCEPT) begin
        out_data      <= rx_data;
        out_addr_flag <= rx_addr_flag;
      end
    end
  end

endmodule

// File: rtl/mdrop_addr_filter_chk.sv
module mdrop_addr_filter_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_nine_bit_en,
  input logic              cfg_auto_addr,
  input logic              host_gate_wr,
  input logic              host_gate_val,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_addr_flag,
  input logic              out_accept,
  input logic              out_drop,
  input logic [DATA_W-1:0] out_data,
  input logic              gate_active
);

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
    !(out_accept && out_drop));                                        // R10
  AST_VERDICT_NEEDS_CHAR: assert property (@(posedge clk) disable iff (rst)
    (out_accept || out_drop) |-> $past(rx_valid));                     // R10
  AST_CHAR_GETS_VERDICT: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> (out_accept || out_drop));                            // R10
  AST_PLAIN_MODE_ACCEPTS: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !cfg_nine_bit_en) |=> out_accept);                    // R2
  AST_GATED_DATA_DROPS: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && cfg_nine_bit_en && !rx_addr_flag && gate_active) |=> out_drop); // R3
  AST_HOST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
    host_gate_wr |=> (gate_active == $past(host_gate_val)));           // R5
  AST_AUTO_GATE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_addr_flag && cfg_nine_bit_en && cfg_auto_addr && !host_gate_wr)
      |=> (gate_active == out_drop));                                  // R9
  AST_ACCEPT_DATA: assert property (@(posedge clk) disable iff (rst)
    out_accept |-> (out_data == $past(rx_data)));                      // R11

endmodule

bind mdrop_addr_filter mdrop_addr_filter_chk #(
  .DATA_W(DATA_W)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .cfg_nine_bit_en(cfg_nine_bit_en),
  .cfg_auto_addr  (cfg_auto_addr),
  .host_gate_wr   (host_gate_wr),
  .host_gate_val  (host_gate_val),
  .rx_valid       (rx_valid),
  .rx_data        (rx_data),
  .rx_addr_flag   (rx_addr_flag),
  .out_accept     (out_accept),
  .out_drop       (out_drop),
  .out_data       (out_data),
  .gate_active    (gate_active)
);

// File: tb/test_mdrop_addr_filter.sv
module test_mdrop_addr_filter;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_nine_bit_en = 1'b0;
  logic          cfg_auto_addr = 1'b0;
  logic [DW-1:0] cfg_node_addr = '0;
  logic [DW-1:0] cfg_node_mask = '0;
  logic          host_gate_wr = 1'b0;
  logic          host_gate_val = 1'b0;
  logic          rx_valid = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic          rx_addr_flag = 1'b0;
  logic          out_accept;
  logic          out_drop;
  logic [DW-1:0] out_data;
  logic          out_addr_flag;
  logic          gate_active;

  always #5 clk = ~clk;

  mdrop_addr_filter #(.DATA_W(DW)) i_mdrop_addr_filter (
    .clk(clk), .rst(rst),
    .cfg_nine_bit_en(cfg_nine_bit_en), .cfg_auto_addr(cfg_auto_addr),
    .cfg_node_addr(cfg_node_addr), .cfg_node_mask(cfg_node_mask),
    .host_gate_wr(host_gate_wr), .host_gate_val(host_gate_val),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_addr_flag(rx_addr_flag),
    .out_accept(out_accept), .out_drop(out_drop), .out_data(out_data),
    .out_addr_flag(out_addr_flag), .gate_active(gate_active)
  );

  typedef struct packed {
    logic          acc;
    logic [DW-1:0] d;
    logic          f;
    logic          g;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    total = 0;
  int    bad = 0;
  logic  mdl_gate = 1'b1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Driver: one character per call, optional host gate write in the same cycle
  task automatic send(input logic [DW-1:0] d, input logic f, input string req,
                      input bit hw = 0, input logic hv = 0);
    exp_t  e;
    logic  hit;
    @(negedge clk);
    rx_valid = 1; rx_data = d; rx_addr_flag = f;
    host_gate_wr = hw; host_gate_val = hv;
    hit = (((d ^ cfg_node_addr) & cfg_node_mask) == '0) ||
          ((d & cfg_node_mask) == cfg_node_mask);
    e.d = d; e.f = f; e.g = mdl_gate;
    if (!cfg_nine_bit_en) e.acc = 1;
    else if (f && cfg_auto_addr) begin e.acc = hit; e.g = !hit; end
    else if (f) e.acc = 1;
    else e.acc = !mdl_gate;
    if (hw) e.g = hv;
    mdl_gate = e.g;
    exp_q.push_back(e);
    tag_q.push_back(req);
    @(negedge clk);
    rx_valid = 0; host_gate_wr = 0;
  endtask

  task automatic host_write(input logic v);
    @(negedge clk);
    host_gate_wr = 1; host_gate_val = v;
    @(negedge clk);
    host_gate_wr = 0;
    mdl_gate = v;
    check(gate_active == v, "R5", "gate after host write", gate_active, v);
  endtask

  // Monitor: pop and compare as verdicts appear
  always @(negedge clk) begin
    if (!rst && (out_accept || out_drop)) begin
      if (exp_q.size() == 0) begin
        check(0, "R10", "unexpected verdict", {out_accept, out_drop}, 0);
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_accept == e.acc && out_drop == !e.acc, t, "accept/drop",
              {out_accept, out_drop}, {e.acc, !e.acc});
        check(gate_active == e.g, t, "gate", gate_active, e.g);
        if (e.acc)
          check(out_data == e.d && out_addr_flag == e.f, "R11", "data/flag",
                {out_addr_flag, out_data}, {e.f, e.d});
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    check(0, "R10", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(gate_active == 1 && !out_accept && !out_drop, "R1", "reset state",
          {gate_active, out_accept, out_drop}, 3'b100);

    // R2: plain mode passes everything
    cfg_auto_addr = 1; cfg_node_mask = 8'hFF; cfg_node_addr = 8'h10;
    send(8'h55, 0, "R2");
    send(8'hA3, 1, "R2");
    cfg_auto_addr = 0;

    // 9-bit, manual gate
    cfg_nine_bit_en = 1;
    send(8'h11, 0, "R3");
    send(8'h42, 1, "R6");
    host_write(0);
    send(8'h22, 0, "R4");
    send(8'h23, 1, "R6");
    host_write(1);

    // auto address, partial mask
    cfg_auto_addr = 1; cfg_node_addr = 8'h5A; cfg_node_mask = 8'hF0;
    send(8'h5C, 1, "R7");
    send(8'h33, 0, "R4");
    send(8'h37, 1, "R9");
    send(8'h44, 0, "R3");
    send(8'hF1, 1, "R8");
    send(8'h66, 0, "R4");

    // full mask
    cfg_node_mask = 8'hFF;
    send(8'h5B, 1, "R9");
    send(8'h5A, 1, "R7");
    send(8'h3C, 1, "R9");
    send(8'hFF, 1, "R8");

    // host write beats a missing address in the same cycle
    send(8'h01, 1, "R5", 1, 0);
    send(8'h77, 0, "R4");

    // plain mode again while auto is set: gate untouched
    cfg_nine_bit_en = 0;
    send(8'h02, 1, "R2");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R10", "missing verdicts", exp_q.size(), 0);
    check(!out_accept && !out_drop, "R10", "idle verdict", {out_accept, out_drop}, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule